// File: doc/BRIEF.md
# SDRAM Command Timing Scheduler

This block sits between a request arbiter and the pins of a single data rate SDRAM interface. It takes one abstract request at a time. A request names an operation, a chip-select, a bank and an address. The operation is activate, read, write, precharge, load-mode or refresh. The block holds the request until every programmed inter-command delay for that chip-select and bank has expired. It then drives the command on the shared command and address bus for that cycle and raises `req_ready` in the same cycle. In every other cycle the bus carries no command.

Reads and writes are followed by a data window. For reads, a data-valid strobe follows the command after the programmed CAS latency. It stays high for as many cycles as the transfer has words. A transfer can be shorter than the programmed memory burst, or the memory can run in full-page mode. In either case the block cuts the burst off with a burst-terminate command, which it issues on its own. All delays, the CAS latency, the burst setting and the mobile-DDR mode are static configuration inputs. They change only while the block is idle.

Top module: `sdram_cmd_sched`

## Requirements
- R1: Each cycle either carries no command or carries exactly one command, on one chip-select. No command means all `cmd_cs_n` high and {ras_n,cas_n,we_n}=111. The selected chip-select is driven low and {ras_n,cas_n,we_n} encodes the command: activate 011, read 101, write 100, precharge 010, refresh 001, load-mode 000, burst-terminate 110. For a request command, `cmd_ba` and `cmd_addr` carry the request's bank and address.
- R2: `req_ready` is high only when `req_valid` is high and the request may legally issue in that cycle. The request's command appears on the bus in that same cycle. Operation codes: 0 activate, 1 read, 2 write, 3 precharge, 4 refresh, 5 load-mode. Codes 6 and 7 are never accepted. A programmed delay d issued at cycle n allows the dependent command at cycle n+max(d,1) at the earliest.
- R3: An activate to a bank waits tRC after the last activate to that bank or the last refresh of its chip-select. It also waits tRP after the last precharge of that bank, tRRD after any activate on the same chip-select, and tMRD after a load-mode on that chip-select.
- R4: A read or write to a bank waits tRCD after the last activate to that bank, and tMRD after a load-mode on its chip-select.
- R5: A precharge to a bank waits tRAS after the last activate to that bank, tWR after the last write to that bank, and tMRD after a load-mode on its chip-select.
- R6: A refresh waits tRP after the last precharge of every bank of its chip-select and tRC after every activate or refresh there. A load-mode waits tRP for every bank and tMRD after the previous load-mode on that chip-select.
- R7: A read waits tWTR after the last write on its chip-select only while `cfg_ddr` is high. Otherwise tWTR has no effect.
- R8: For a read issued at cycle n with CAS latency CL (1 to 7) and B words, `rd_valid` is high exactly in cycles n+CL to n+CL+B-1. Back-to-back bursts give a continuous strobe.
- R9: The requested length is `req_len` 0, 1 or 2, meaning 1, 4 or 8 words. The memory burst is `cfg_burst` 0, 1, 2 or 3, meaning 1, 4, 8 words or full page. For a fixed burst, B is the smaller of the two lengths. For full page, B is the requested length. When the requested length is below the fixed burst, or the burst is full page, a burst-terminate is issued at cycle n+B on the burst's chip-select and bank. Otherwise no burst-terminate is issued.
- R10: After a read or write at cycle n, no read, write, precharge, refresh or load-mode issues before n+B, or before n+B+1 when a burst-terminate is due. An activate may issue in any cycle except the burst-terminate cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_t_rc | input | TW | Activate-to-activate delay, same bank |
| cfg_t_rp | input | TW | Precharge-to-activate delay |
| cfg_t_rcd | input | TW | Activate-to-read/write delay |
| cfg_t_mrd | input | TW | Load-mode-to-command delay |
| cfg_t_wr | input | TW | Write-to-precharge delay |
| cfg_t_ras | input | TW | Activate-to-precharge delay |
| cfg_t_rrd | input | TW | Activate-to-activate delay, same chip-select |
| cfg_t_wtr | input | TW | Write-to-read delay (mobile DDR mode) |
| cfg_cas | input | 3 | CAS latency, 1 to 7 |
| cfg_burst | input | 2 | Memory burst setting |
| cfg_ddr | input | 1 | Mobile DDR mode enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request issued this cycle |
| req_op | input | 3 | Operation code |
| req_cs | input | CSW | Chip-select index |
| req_bank | input | BAW | Bank index |
| req_addr | input | AW | Row or column address |
| req_len | input | 2 | Transfer length code |
| cmd_cs_n | output | NCS | Chip-selects, active low |
| cmd_ras_n | output | 1 | Row strobe |
| cmd_cas_n | output | 1 | Column strobe |
| cmd_we_n | output | 1 | Write enable |
| cmd_ba | output | BAW | Bank address |
| cmd_addr | output | AW | Address bus |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The assertions assume that the configuration inputs stay constant while any delay, burst or read strobe is in flight, and that `cfg_cas` is never zero. They also assume that an arbiter holds a request steady until it is accepted. The stimulus changes configuration only after thirty idle cycles, which is longer than any delay, burst or latency it programs. It draws CAS latencies from 1 to 7, holds every request until `req_ready`, and predicts each issue cycle from its own record of past commands.

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched #(
  parameter int NCS   = 2,
  parameter int NBANK = 4,
  parameter int AW    = 13,
  parameter int TW    = 5,
  localparam int CSW  = $clog2(NCS),
  localparam int BAW  = $clog2(NBANK),
  localparam int CW   = 4,
  localparam int SHW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  cfg_t_rc,
  input  logic [TW-1:0]  cfg_t_rp,
  input  logic [TW-1:0]  cfg_t_rcd,
  input  logic [TW-1:0]  cfg_t_mrd,
  input  logic [TW-1:0]  cfg_t_wr,
  input  logic [TW-1:0]  cfg_t_ras,
  input  logic [TW-1:0]  cfg_t_rrd,
  input  logic [TW-1:0]  cfg_t_wtr,
  input  logic [2:0]     cfg_cas,
  input  logic [1:0]     cfg_burst,
  input  logic           cfg_ddr,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_op,
  input  logic [CSW-1:0] req_cs,
  input  logic [BAW-1:0] req_bank,
  input  logic [AW-1:0]  req_addr,
  input  logic [1:0]     req_len,
  output logic [NCS-1:0] cmd_cs_n,
  output logic           cmd_ras_n,
  output logic           cmd_cas_n,
  output logic           cmd_we_n,
  output logic [BAW-1:0] cmd_ba,
  output logic [AW-1:0]  cmd_addr,
  output logic           rd_valid
);
  localparam logic [2:0] OP_ACT = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2,
                         OP_PRE = 3'd3, OP_REF = 3'd4, OP_MRS = 3'd5;

  logic [TW-1:0] c_rc  [NCS][NBANK];
  logic [TW-1:0] c_rcd [NCS][NBANK];
  logic [TW-1:0] c_ras [NCS][NBANK];
  logic [TW-1:0] c_rp  [NCS][NBANK];
  logic [TW-1:0] c_wr  [NCS][NBANK];
  logic [TW-1:0] c_rrd [NCS];
  logic [TW-1:0] c_mrd [NCS];
  logic [TW-1:0] c_wtr [NCS];

  logic [CW-1:0]  bcnt;
  logic           bneed, brd;
  logic [CSW-1:0] bcs;
  logic [BAW-1:0] bbank;
  logic [SHW-1:0] beat_sh;

  function automatic logic expired(input logic [TW-1:0] v);
    return v <= TW'(1);
  endfunction

  logic rp_all, rc_all, allowed, bst_fire, bus_free, issue, beat_now, is_rw;
  logic [CW-1:0] req_words, mem_words, rw_beats;
  logic rw_need;

  assign bst_fire = (bcnt == CW'(1)) && bneed;
  assign bus_free = bcnt <= CW'(1);
  assign is_rw    = (req_op == OP_RD) || (req_op == OP_WR);

  always_comb begin
    rp_all = 1'b1;
    rc_all = 1'b1;
    for (int b = 0; b < NBANK; b++) begin
      rp_all = rp_all & expired(c_rp[req_cs][BAW'(b)]);
      rc_all = rc_all & expired(c_rc[req_cs][BAW'(b)]);
    end
  end

  always_comb begin
    case (req_op)
      OP_ACT: allowed = expired(c_rc[req_cs][req_bank]) && expired(c_rp[req_cs][req_bank])
                     && expired(c_rrd[req_cs]) && expired(c_mrd[req_cs]);
      OP_RD:  allowed = bus_free && expired(c_rcd[req_cs][req_bank]) && expired(c_mrd[req_cs])
                     && (!cfg_ddr || expired(c_wtr[req_cs]));
      OP_WR:  allowed = bus_free && expired(c_rcd[req_cs][req_bank]) && expired(c_mrd[req_cs]);
      OP_PRE: allowed = bus_free && expired(c_ras[req_cs][req_bank])
                     && expired(c_wr[req_cs][req_bank]) && expired(c_mrd[req_cs]);
      OP_REF: allowed = bus_free && rp_all && rc_all && expired(c_mrd[req_cs]);
      OP_MRS: allowed = bus_free && rp_all && expired(c_mrd[req_cs]);
      default: allowed = 1'b0;
    endcase
  end

  assign issue     = req_valid && !bst_fire && allowed;
  assign req_ready = issue;

  assign req_words = (req_len == 2'd0) ? CW'(1) : (req_len == 2'd1) ? CW'(4) : CW'(8);
  assign mem_words = (cfg_burst == 2'd0) ? CW'(1) : (cfg_burst == 2'd1) ? CW'(4) : CW'(8);
  assign rw_beats  = (cfg_burst == 2'd3 || req_words < mem_words) ? req_words : mem_words;
  assign rw_need   = (cfg_burst == 2'd3) || (req_words < mem_words);

  always_comb begin
    cmd_cs_n  = '1;
    {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b111;
    cmd_ba    = '0;
    cmd_addr  = '0;
    if (bst_fire) begin
      cmd_cs_n[bcs] = 1'b0;
      {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b110;
      cmd_ba = bbank;
    end else if (issue) begin
      cmd_cs_n[req_cs] = 1'b0;
      cmd_ba   = req_bank;
      cmd_addr = req_addr;
      case (req_op)
        OP_ACT:  {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b011;
        OP_RD:   {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b101;
        OP_WR:   {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b100;
        OP_PRE:  {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b010;
        OP_REF:  {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b001;
        default: {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b000;
      endcase
    end
  end

  assign beat_now = (issue && req_op == OP_RD) || (bcnt >= CW'(2) && brd);
  assign rd_valid = (cfg_cas == 3'd0) ? 1'b0 : beat_sh[cfg_cas - 3'd1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCS; c++) begin
        c_rrd[c] <= '0; c_mrd[c] <= '0; c_wtr[c] <= '0;
        for (int b = 0; b < NBANK; b++) begin
          c_rc[c][b] <= '0; c_rcd[c][b] <= '0; c_ras[c][b] <= '0;
          c_rp[c][b] <= '0; c_wr[c][b] <= '0;
        end
      end
      bcnt    <= '0;
      bneed   <= 1'b0;
      brd     <= 1'b0;
      bcs     <= '0;
      bbank   <= '0;
      beat_sh <= '0;
    end else begin
      for (int c = 0; c < NCS; c++) begin
        if (c_rrd[c] != 0) c_rrd[c] <= c_rrd[c] - 1'b1;
        if (c_mrd[c] != 0) c_mrd[c] <= c_mrd[c] - 1'b1;
        if (c_wtr[c] != 0) c_wtr[c] <= c_wtr[c] - 1'b1;
        for (int b = 0; b < NBANK; b++) begin
          if (c_rc[c][b]  != 0) c_rc[c][b]  <= c_rc[c][b]  - 1'b1;
          if (c_rcd[c][b] != 0) c_rcd[c][b] <= c_rcd[c][b] - 1'b1;
          if (c_ras[c][b] != 0) c_ras[c][b] <= c_ras[c][b] - 1'b1;
          if (c_rp[c][b]  != 0) c_rp[c][b]  <= c_rp[c][b]  - 1'b1;
          if (c_wr[c][b]  != 0) c_wr[c][b]  <= c_wr[c][b]  - 1'b1;
        end
      end
      if (issue) begin
        case (req_op)
          OP_ACT: begin
            c_rc[req_cs][req_bank]  <= cfg_t_rc;
            c_rcd[req_cs][req_bank] <= cfg_t_rcd;
            c_ras[req_cs][req_bank] <= cfg_t_ras;
            c_rrd[req_cs]           <= cfg_t_rrd;
          end
          OP_WR: begin
            c_wr[req_cs][req_bank] <= cfg_t_wr;
            c_wtr[req_cs]          <= cfg_t_wtr;
          end
          OP_PRE: c_rp[req_cs][req_bank] <= cfg_t_rp;
          OP_REF: for (int b = 0; b < NBANK; b++) c_rc[req_cs][BAW'(b)] <= cfg_t_rc;
          OP_MRS: c_mrd[req_cs] <= cfg_t_mrd;
          default: ;
        endcase
      end
      if (issue && is_rw) begin
        bcnt  <= rw_beats;
        bneed <= rw_need;
        brd   <= (req_op == OP_RD);
        bcs   <= req_cs;
        bbank <= req_bank;
      end else if (bcnt != 0) begin
        bcnt <= bcnt - 1'b1;
      end
      beat_sh <= {beat_sh[SHW-2:0], beat_now};
    end
  end

  logic is_act_pin, is_rd_pin, is_bst_pin, any_cs;
  assign any_cs     = cmd_cs_n != '1;
  assign is_act_pin = any_cs && {cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b011;
  assign is_rd_pin  = any_cs && {cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b101;
  assign is_bst_pin = any_cs && {cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b110;

  assert_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  assert_single_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_cs |-> $countones(~cmd_cs_n) == 1);
  assert_idle_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !is_bst_pin |-> !any_cs && cmd_ras_n && cmd_cas_n && cmd_we_n);
  assert_rrd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act_pin && cfg_t_rrd > TW'(1)) |=> !(is_act_pin && cmd_cs_n == $past(cmd_cs_n)));
  assert_cl1_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd_pin && cfg_cas == 3'd1) |=> rd_valid);
  assert_bst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_bst_pin |=> !is_bst_pin);
endmodule

// File: tb/sdram_cmd_sched_test.sv
module sdram_cmd_sched_test;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [4:0] t_rc, t_rp, t_rcd, t_mrd, t_wr, t_ras, t_rrd, t_wtr;
  logic [2:0] cas;
  logic [1:0] burst;
  logic ddr;
  logic req_valid, req_ready;
  logic [2:0] req_op;
  logic req_cs;
  logic [1:0] req_bank;
  logic [12:0] req_addr;
  logic [1:0] req_len;
  logic [1:0] cs_n;
  logic ras_n, cas_n, we_n, rd_valid;
  logic [1:0] ba;
  logic [12:0] addr;

  sdram_cmd_sched uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_t_rc(t_rc), .cfg_t_rp(t_rp), .cfg_t_rcd(t_rcd), .cfg_t_mrd(t_mrd),
    .cfg_t_wr(t_wr), .cfg_t_ras(t_ras), .cfg_t_rrd(t_rrd), .cfg_t_wtr(t_wtr),
    .cfg_cas(cas), .cfg_burst(burst), .cfg_ddr(ddr),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_cs(req_cs), .req_bank(req_bank), .req_addr(req_addr), .req_len(req_len),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(ba), .cmd_addr(addr), .rd_valid(rd_valid));

  int total = 0, bad = 0;
  int cyc = 0;
  bit mon_on = 0, finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int l_act [2][4], l_pre [2][4], l_wr [2][4];
  int l_actcs [2], l_ref [2], l_mrs [2], l_wrcs [2];
  int b_start, b_beats, b_cs, b_bk, exp_bst;
  bit b_need;
  bit exp_rv [2048];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int d1(input int v); return (v < 1) ? 1 : v; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int words(input int code); return code == 0 ? 1 : code == 1 ? 4 : 8; endfunction

  function automatic int earliest(input int op, input int c, input int b, input int st);
    int e = st;
    int g = b_start + b_beats + (b_need ? 1 : 0);
    e = mx(e, l_mrs[c] + d1(t_mrd));
    case (op)
      0: begin
        e = mx(e, l_act[c][b] + d1(t_rc));
        e = mx(e, l_ref[c] + d1(t_rc));
        e = mx(e, l_pre[c][b] + d1(t_rp));
        e = mx(e, l_actcs[c] + d1(t_rrd));
        if (b_need && e == b_start + b_beats) e++;
      end
      1: begin
        e = mx(e, g);
        e = mx(e, l_act[c][b] + d1(t_rcd));
        if (ddr) e = mx(e, l_wrcs[c] + d1(t_wtr));
      end
      2: begin e = mx(e, g); e = mx(e, l_act[c][b] + d1(t_rcd)); end
      3: begin
        e = mx(e, g);
        e = mx(e, l_act[c][b] + d1(t_ras));
        e = mx(e, l_wr[c][b] + d1(t_wr));
      end
      4: begin
        e = mx(e, g);
        e = mx(e, l_ref[c] + d1(t_rc));
        for (int k = 0; k < 4; k++) begin
          e = mx(e, l_pre[c][k] + d1(t_rp));
          e = mx(e, l_act[c][k] + d1(t_rc));
        end
      end
      default: begin
        e = mx(e, g);
        for (int k = 0; k < 4; k++) e = mx(e, l_pre[c][k] + d1(t_rp));
      end
    endcase
    return e;
  endfunction

  function automatic bit [2:0] enc(input int op);
    case (op)
      0: return 3'b011; 1: return 3'b101; 2: return 3'b100;
      3: return 3'b010; 4: return 3'b001; default: return 3'b000;
    endcase
  endfunction

  function automatic string tag(input int op);
    case (op)
      0: return "R3"; 1, 2: return "R4"; 3: return "R5"; default: return "R6";
    endcase
  endfunction

  task automatic do_req(input int op, input int c, input int b, input int a, input int len, input string rq);
    int st, e, got, rl, pb;
    @(negedge clk);
    req_op = op[2:0]; req_cs = c[0]; req_bank = b[1:0]; req_addr = a[12:0]; req_len = len[1:0];
    req_valid = 1;
    st = cyc;
    e = earliest(op, c, b, st);
    got = -1;
    for (int k = 0; k < 200; k++) begin
      #1;
      if (req_ready) begin
        got = cyc;
        check(cs_n == ~(2'b01 << c) && {ras_n, cas_n, we_n} == enc(op) && ba == b[1:0] && addr == a[12:0],
              "R1", {cs_n, ras_n, cas_n, we_n}, {~(2'b01 << c), enc(op)});
        break;
      end
      @(negedge clk);
    end
    check(got == e, (rq != "") ? rq : tag(op), got, e);
    if (got >= 0) begin
      case (op)
        0: begin l_act[c][b] = got; l_actcs[c] = got; end
        3: l_pre[c][b] = got;
        4: l_ref[c] = got;
        5: l_mrs[c] = got;
        default: ;
      endcase
      if (op == 2) begin l_wr[c][b] = got; l_wrcs[c] = got; end
      if (op == 1 || op == 2) begin
        rl = words(len);
        pb = (burst == 3) ? 0 : words(burst);
        b_beats = (pb == 0 || rl < pb) ? rl : pb;
        b_need = (pb == 0) || (rl < pb);
        b_start = got; b_cs = c; b_bk = b;
        exp_bst = b_need ? got + b_beats : -1;
        if (op == 1)
          for (int i = 0; i < b_beats; i++) exp_rv[(got + int'(cas) + i) % 2048] = 1;
      end
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_on) begin
        bit bst;
        int idx;
        bst = (cs_n != 2'b11) && {ras_n, cas_n, we_n} == 3'b110;
        if (bst || cyc == exp_bst)
          check(bst && cyc == exp_bst && cs_n == ~(2'b01 << b_cs) && ba == b_bk[1:0],
                "R9", bst ? cyc : -1, exp_bst);
        idx = cyc % 2048;
        if (rd_valid || exp_rv[idx]) check(rd_valid == exp_rv[idx], "R8", rd_valid, exp_rv[idx]);
        exp_rv[idx] = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int rc, rp, rcd, mrd, wr, ras, rrd, wtr, cl, bl, dd);
    t_rc = rc[4:0]; t_rp = rp[4:0]; t_rcd = rcd[4:0]; t_mrd = mrd[4:0]; t_wr = wr[4:0];
    t_ras = ras[4:0]; t_rrd = rrd[4:0]; t_wtr = wtr[4:0]; cas = cl[2:0]; burst = bl[1:0]; ddr = dd[0];
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      l_actcs[c] = -100; l_ref[c] = -100; l_mrs[c] = -100; l_wrcs[c] = -100;
      for (int b = 0; b < 4; b++) begin l_act[c][b] = -100; l_pre[c][b] = -100; l_wr[c][b] = -100; end
    end
    b_start = -100; b_beats = 1; b_need = 0; b_cs = 0; b_bk = 0; exp_bst = -1;
    foreach (exp_rv[i]) exp_rv[i] = 0;
    void'($urandom(32'd1234));
    set_cfg(7, 3, 3, 2, 2, 5, 2, 2, 3, 2, 0);
    req_valid = 0; req_op = 0; req_cs = 0; req_bank = 0; req_addr = 0; req_len = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    check(!req_ready && cs_n == 2'b11 && {ras_n, cas_n, we_n} == 3'b111 && !rd_valid,
          "R1", {req_ready, cs_n, ras_n, cas_n, we_n, rd_valid}, 7'b0111110);
    rst_n = 1;
    idle(2);
    mon_on = 1;

    req_op = 3'd6; req_valid = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1;
      check(!req_ready && cs_n == 2'b11, "R2", req_ready, 0);
    end
    req_valid = 0;

    do_req(5, 0, 0, 13'h33, 0, "R6");
    do_req(0, 0, 0, 13'h100, 0, "R3");
    do_req(0, 0, 1, 13'h101, 0, "R3");
    do_req(1, 0, 0, 13'h8, 2, "R8");
    do_req(1, 0, 0, 13'h10, 1, "R9");
    do_req(2, 0, 1, 13'h20, 2, "R10");
    do_req(1, 0, 1, 13'h28, 2, "R7");
    do_req(3, 0, 0, 13'h0, 0, "R5");
    do_req(0, 0, 0, 13'h55, 0, "R3");
    do_req(4, 1, 0, 13'h0, 0, "R6");
    do_req(0, 1, 2, 13'h77, 0, "R3");
    idle(30);

    set_cfg(6, 2, 2, 2, 3, 4, 3, 4, 2, 3, 0);
    do_req(1, 0, 0, 13'h4, 0, "R9");
    do_req(1, 0, 0, 13'h4, 2, "R10");
    do_req(0, 0, 3, 13'h9, 0, "R10");
    idle(30);
    set_cfg(6, 2, 2, 2, 3, 4, 3, 4, 5, 0, 0);
    do_req(1, 0, 1, 13'h4, 2, "R9");
    do_req(1, 0, 1, 13'h5, 2, "R8");
    idle(30);
    set_cfg(6, 2, 2, 2, 3, 4, 3, 4, 1, 1, 1);
    do_req(2, 1, 2, 13'h4, 1, "R4");
    do_req(1, 1, 2, 13'h4, 1, "R7");
    idle(30);

    for (int ph = 0; ph < 8; ph++) begin
      set_cfg($urandom_range(0, 9), $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 4),
              $urandom_range(0, 6), $urandom_range(0, 8), $urandom_range(0, 5), $urandom_range(0, 5),
              $urandom_range(1, 7), $urandom_range(0, 3), $urandom_range(0, 1));
      for (int n = 0; n < 60; n++) begin
        int r, op;
        r = $urandom_range(0, 19);
        op = r < 5 ? 0 : r < 10 ? 1 : r < 14 ? 2 : r < 17 ? 3 : r < 19 ? 4 : 5;
        do_req(op, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 8191),
               $urandom_range(0, 2), "");
        if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 6));
      end
      idle(30);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule